// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the programming front end of one eight-line interrupt controller. A host writes bytes to a two-location port (selected by a 1-bit address) and reads bytes back. The decoder turns those bytes into an initialization sequence and into run-time operation commands. Initialization sets the vector base, the cascade arrangement and the operating mode. Operation commands end interrupts, rotate priorities, pick the readable register and arm a one-shot poll. The same block holds the request, in-service and mask registers and resolves priority over them with a rotating priority base.

Request lines are captured on their rising edges. A host may take the winning line in two ways. One is a single-cycle acknowledge strobe, which returns a vector. The other is a poll read, which returns the line number over the data port. A registered interrupt output reports whether an unmasked request currently outranks everything in service.

Top module: `pic_cw_decoder`

## Requirements
- R1: After reset the request, in-service and mask registers are zero, reads of either address return 0x00, `int_out` is low and `ack_vec` is 0x00.
- R2: A write to address 0 with bit 4 set clears the mask, in-service and request registers and begins initialization. The next address-1 write stores the vector base with bits 2:0 forced to zero. An acknowledge then returns base bits 7:3 followed by the 3-bit line number.
- R3: Address-1 writes during initialization follow this sequence. Bit 1 of the start byte (single) skips the cascade word. Bit 0 (fourth word) adds a mode word. After the last word, the next address-1 write loads the mask.
- R4: In the mode word, bit 1 enables auto end-of-interrupt, so an acknowledge sets no in-service bit. Bit 4 enables special nesting: the in-service bit of line 2 is ignored when deciding whether a request may interrupt.
- R5: A request bit is set when its input line rises. A line that stays high does not set the bit again after the bit has been cleared.
- R6: `int_out`, registered one cycle after the state it reflects, is high exactly when an unmasked request has higher priority than the highest-priority in-service line. Priority rank is (line - base) mod 8, with rank 0 highest.
- R7: An acknowledge with a winning line sets that line's in-service bit and clears its request bit. With no winner it returns line 7 and changes nothing.
- R8: An address-0 write with bit 3 set and bit 4 clear is a mode command. If bit 1 is set, bit 0 chooses in-service (1) or request (0) for address-0 reads. If bit 6 is set, bit 5 turns special mask on or off. In special mask, masked in-service lines do not block requests.
- R9: Command 1 (bits 7:5) clears the highest-priority in-service bit. Command 5 does the same and also sets the base to that line plus one.
- R10: Command 3 clears the in-service bit named by bits 2:0. Command 7 also sets the base to that line plus one. Command 6 sets the base to bits 2:0 plus one, mod 8.
- R11: Command 4 enables rotation on auto end-of-interrupt, so each acknowledge sets the base to the acknowledged line plus one. Command 0 disables it.
- R12: Mode-command bit 2 arms a poll. The next read returns the winning line number and clears its request and in-service bits, or returns 7 if there is no winner, and then disarms the poll.
- R13: In normal state an address-1 write loads the mask and an address-1 read returns it. Command 2 changes nothing.
- R14: Read data is registered: `rdata` changes only in the cycle after a read strobe and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 1 | Port location select |
| wdata | input | N | Write byte |
| rdata | output | N | Registered read byte |
| req_in | input | N | Interrupt request lines, rising-edge captured |
| ack | input | 1 | Acknowledge strobe |
| ack_vec | output | N | Registered vector of the acknowledged line |
| int_out | output | 1 | Registered interrupt request to the host |

## Verification
The bench builds the block with its default of eight lines and special nesting on line 2. This is the only width at which the 3-bit command fields, the mod-8 rotation and the spurious value 7 line up. At this width every command code, every path through the initialization sequence and every wrap of the priority base (7 to 0) can be reached with a few pulses. Rotated bases are chosen so that a rotated and an unrotated design pick different winners.

// File: rtl/pic_cw_pkg.sv
package pic_cw_pkg;

  typedef enum logic [1:0] {
    IS_IDLE = 2'd0,
    IS_BASE = 2'd1,
    IS_CASC = 2'd2,
    IS_MODE = 2'd3
  } init_st_e;

  typedef enum logic [2:0] {
    OP_ROT_OFF    = 3'd0,
    OP_NS_EOI     = 3'd1,
    OP_NOP        = 3'd2,
    OP_SP_EOI     = 3'd3,
    OP_ROT_ON     = 3'd4,
    OP_NS_EOI_ROT = 3'd5,
    OP_SET_PRI    = 3'd6,
    OP_SP_EOI_ROT = 3'd7
  } op_e;

  // address-0 byte fields
  localparam int B_START   = 4;
  localparam int B_MODECMD = 3;
  localparam int B_POLL    = 2;
  localparam int B_RSEL_EN = 1;
  localparam int B_RSEL    = 0;
  localparam int B_SMM_EN  = 6;
  localparam int B_SMM     = 5;
  localparam int B_FOUR    = 0;
  localparam int B_SINGLE  = 1;
  // mode word fields
  localparam int B_AEOI    = 1;
  localparam int B_SNEST   = 4;

endpackage

// File: rtl/pic_prio_find.sv
module pic_prio_find #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  mask,
  input  logic [LW-1:0] base,
  output logic          found,
  output logic [LW-1:0] rank
);
  // Scan from the lowest rank last so it wins.
  always_comb begin
    found = 1'b0;
    rank  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      logic [LW-1:0] idx;
      idx = LW'(base + LW'(k));
      if (mask[idx]) begin
        found = 1'b1;
        rank  = LW'(k);
      end
    end
  end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cw_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  logic     start_four,
  input  logic     start_single,
  input  logic     step,
  output init_st_e state
);
  logic four_q, single_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= IS_IDLE;
      four_q   <= 1'b0;
      single_q <= 1'b0;
    end else if (start) begin
      state    <= IS_BASE;
      four_q   <= start_four;
      single_q <= start_single;
    end else if (step) begin
      case (state)
        IS_BASE: state <= single_q ? (four_q ? IS_MODE : IS_IDLE) : IS_CASC;
        IS_CASC: state <= four_q ? IS_MODE : IS_IDLE;
        IS_MODE: state <= IS_IDLE;
        default: state <= IS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pic_cw_decoder.sv
module pic_cw_decoder
  import pic_cw_pkg::*;
#(
  parameter int N          = 8,
  parameter int SNEST_LINE = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic         addr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] rdata,
  input  logic [N-1:0] req_in,
  input  logic         ack,
  output logic [N-1:0] ack_vec,
  output logic         int_out
);
  localparam int LW = $clog2(N);
  localparam logic [LW-1:0] SPUR = {LW{1'b1}};

  logic [N-1:0]  irr_q, isr_q, imr_q, hist_q, vb_q;
  logic [LW-1:0] base_q;
  logic          rsel_q, poll_q, smm_q, aeoi_q, rot_q, snest_q;
  logic [N-1:0]  rdata_q, ackv_q;
  logic          int_q;
  init_st_e      init_st;

  logic [N-1:0]  irr_n, isr_n, imr_n, vb_n, rdata_n, ackv_n;
  logic [LW-1:0] base_n;
  logic          rsel_n, poll_n, smm_n, aeoi_n, rot_n, snest_n;

  // ---------------- priority resolution ----------------
  logic [N-1:0]  pend_mask, cur_mask;
  logic          p_found, c_found, i_found, win_valid;
  logic [LW-1:0] p_rank, c_rank, i_rank, win_line, top_isr_line;

  assign pend_mask = irr_q & ~imr_q;

  always_comb begin
    cur_mask = isr_q;
    if (smm_q)   cur_mask = cur_mask & ~imr_q;
    if (snest_q) cur_mask[SNEST_LINE] = 1'b0;
  end

  pic_prio_find #(.N(N), .LW(LW)) u_find_pend (
    .mask(pend_mask), .base(base_q), .found(p_found), .rank(p_rank));
  pic_prio_find #(.N(N), .LW(LW)) u_find_cur (
    .mask(cur_mask), .base(base_q), .found(c_found), .rank(c_rank));
  pic_prio_find #(.N(N), .LW(LW)) u_find_isr (
    .mask(isr_q), .base(base_q), .found(i_found), .rank(i_rank));

  assign win_valid    = p_found && (!c_found || (p_rank < c_rank));
  assign win_line     = LW'(p_rank + base_q);
  assign top_isr_line = LW'(i_rank + base_q);

  // ---------------- initialization sequencer ----------------
  logic start_w, step_w;
  assign start_w = wr_en && !addr && wdata[B_START];
  assign step_w  = wr_en && addr && (init_st != IS_IDLE);

  pic_init_seq u_seq (
    .clk(clk), .rst(rst), .start(start_w),
    .start_four(wdata[B_FOUR]), .start_single(wdata[B_SINGLE]),
    .step(step_w), .state(init_st));

  // ---------------- next-state decode ----------------
  always_comb begin
    op_e op;
    op      = op_e'(wdata[7:5]);
    irr_n   = irr_q | (req_in & ~hist_q);
    isr_n   = isr_q;
    imr_n   = imr_q;
    vb_n    = vb_q;
    base_n  = base_q;
    rsel_n  = rsel_q;
    poll_n  = poll_q;
    smm_n   = smm_q;
    aeoi_n  = aeoi_q;
    rot_n   = rot_q;
    snest_n = snest_q;
    rdata_n = rdata_q;
    ackv_n  = ackv_q;

    if (ack) begin
      if (win_valid) begin
        ackv_n = {vb_q[N-1:LW], win_line};
        if (aeoi_q) begin
          if (rot_q) base_n = LW'(win_line + 1'b1);
        end else begin
          isr_n[win_line] = 1'b1;
        end
        irr_n[win_line] = 1'b0;
      end else begin
        ackv_n = {vb_q[N-1:LW], SPUR};
      end
    end

    if (rd_en) begin
      if (poll_q) begin
        poll_n = 1'b0;
        if (win_valid) begin
          rdata_n         = N'(win_line);
          irr_n[win_line] = 1'b0;
          isr_n[win_line] = 1'b0;
        end else begin
          rdata_n = N'(SPUR);
        end
      end else if (addr) begin
        rdata_n = imr_q;
      end else begin
        rdata_n = rsel_q ? isr_q : irr_q;
      end
    end

    if (wr_en) begin
      if (!addr) begin
        if (wdata[B_START]) begin
          irr_n = '0; isr_n = '0; imr_n = '0; vb_n = '0; base_n = '0;
          rsel_n = 1'b0; poll_n = 1'b0; smm_n = 1'b0;
          aeoi_n = 1'b0; rot_n = 1'b0; snest_n = 1'b0;
        end else if (wdata[B_MODECMD]) begin
          if (wdata[B_POLL])    poll_n = 1'b1;
          if (wdata[B_RSEL_EN]) rsel_n = wdata[B_RSEL];
          if (wdata[B_SMM_EN])  smm_n  = wdata[B_SMM];
        end else begin
          case (op)
            OP_ROT_OFF: rot_n = 1'b0;
            OP_ROT_ON:  rot_n = 1'b1;
            OP_NS_EOI, OP_NS_EOI_ROT: begin
              if (i_found) begin
                isr_n[top_isr_line] = 1'b0;
                if (op == OP_NS_EOI_ROT) base_n = LW'(top_isr_line + 1'b1);
              end
            end
            OP_SP_EOI:  isr_n[wdata[LW-1:0]] = 1'b0;
            OP_SET_PRI: base_n = LW'(wdata[LW-1:0] + 1'b1);
            OP_SP_EOI_ROT: begin
              isr_n[wdata[LW-1:0]] = 1'b0;
              base_n = LW'(wdata[LW-1:0] + 1'b1);
            end
            default: ;
          endcase
        end
      end else begin
        case (init_st)
          IS_IDLE: imr_n = wdata;
          IS_BASE: vb_n  = {wdata[N-1:LW], {LW{1'b0}}};
          IS_MODE: begin
            snest_n = wdata[B_SNEST];
            aeoi_n  = wdata[B_AEOI];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q <= '0; isr_q <= '0; imr_q <= '0; hist_q <= '0; vb_q <= '0;
      base_q <= '0; rsel_q <= 1'b0; poll_q <= 1'b0; smm_q <= 1'b0;
      aeoi_q <= 1'b0; rot_q <= 1'b0; snest_q <= 1'b0;
      rdata_q <= '0; ackv_q <= '0; int_q <= 1'b0;
    end else begin
      irr_q <= irr_n; isr_q <= isr_n; imr_q <= imr_n; hist_q <= req_in;
      vb_q <= vb_n; base_q <= base_n; rsel_q <= rsel_n; poll_q <= poll_n;
      smm_q <= smm_n; aeoi_q <= aeoi_n; rot_q <= rot_n; snest_q <= snest_n;
      rdata_q <= rdata_n; ackv_q <= ackv_n; int_q <= win_valid;
    end
  end

  assign rdata   = rdata_q;
  assign ack_vec = ackv_q;
  assign int_out = int_q;
endmodule

// File: rtl/pic_cw_decoder_chk.sv
module pic_cw_decoder_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic         rd_en,
  input logic         addr,
  input logic [N-1:0] wdata,
  input logic [N-1:0] rdata,
  input logic         int_out,
  input logic [N-1:0] irr_q,
  input logic [N-1:0] isr_q,
  input logic [N-1:0] imr_q,
  input logic         poll_q,
  input logic [1:0]   init_st
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!int_out && rdata == '0)); // R1

  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr && wdata[4]) |=>
      (imr_q == '0 && isr_q == '0 && irr_q == '0 && init_st == 2'd1)); // R2

  AST_INT_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
    int_out |-> ($past(irr_q & ~imr_q) != '0)); // R6

  AST_POLL_ONESHOT: assert property (@(posedge clk) disable iff (rst)
    (rd_en && poll_q && !wr_en) |=> !poll_q); // R12

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr && init_st == 2'd0) |=> (imr_q == $past(wdata))); // R13

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R14
endmodule

bind pic_cw_decoder pic_cw_decoder_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .int_out(int_out), .irr_q(irr_q),
  .isr_q(isr_q), .imr_q(imr_q), .poll_q(poll_q), .init_st(init_st));

// File: tb/test_pic_cw_decoder.sv
module test_pic_cw_decoder;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, ack = 1'b0;
  logic [7:0] wdata = 8'h00, req_in = 8'h00;
  logic [7:0] rdata, ack_vec;
  logic       int_out;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  pic_cw_decoder i_pic_cw_decoder (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .req_in(req_in), .ack(ack),
    .ack_vec(ack_vec), .int_out(int_out));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic do_ack(output logic [7:0] v);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0; v = ack_vec;
  endtask

  task automatic pulse(input logic [7:0] lines);
    @(negedge clk); req_in = req_in | lines;
    @(negedge clk); req_in = req_in & ~lines;
  endtask

  task automatic int_chk(input string req, input logic exp);
    @(negedge clk); chk(req, {7'd0, int_out}, {7'd0, exp});
  endtask

  task automatic init(input logic [7:0] mode);
    wr(0, 8'h13); wr(1, 8'h40); wr(1, mode);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 int_out", {7'd0, int_out}, 8'h00);
    chk("R1 ack_vec", ack_vec, 8'h00);
    rd(0, d); chk("R1 request read", d, 8'h00);
    rd(1, d); chk("R1 mask read", d, 8'h00);
  endtask

  task automatic t_init_paths;
    logic [7:0] d;
    wr(1, 8'h0F);
    wr(0, 8'h10);
    rd(1, d); chk("R2 mask cleared by init", d, 8'h00);
    wr(1, 8'h45); wr(1, 8'h00); wr(1, 8'hAA);
    rd(1, d); chk("R3 cascade path then mask", d, 8'hAA);
    wr(0, 8'h12); wr(1, 8'h21); wr(1, 8'h33);
    rd(1, d); chk("R3 single path then mask", d, 8'h33);
    wr(1, 8'h00);
    pulse(8'h08);
    do_ack(d); chk("R2 vector base low bits cleared", d, 8'h23);
    wr(0, 8'h11); wr(1, 8'h08); wr(1, 8'h00); wr(1, 8'h00); wr(1, 8'h5A);
    rd(1, d); chk("R3 cascade plus fourth word", d, 8'h5A);
    wr(0, 8'h0B);
    rd(0, d); chk("R2 in-service cleared by init", d, 8'h00);
  endtask

  task automatic t_edge_ack;
    logic [7:0] d;
    init(8'h00);
    @(negedge clk); req_in[5] = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(0, d); chk("R5 rising edge captured", d, 8'h20);
    do_ack(d); chk("R7 ack vector", d, 8'h45);
    rd(0, d); chk("R5 held line not recaptured", d, 8'h00);
    wr(0, 8'h0B);
    rd(0, d); chk("R7 ack sets in-service", d, 8'h20);
    do_ack(d); chk("R7 spurious ack", d, 8'h47);
    wr(0, 8'h20);
    rd(0, d); chk("R9 eoi clears", d, 8'h00);
    @(negedge clk); req_in[5] = 1'b0;
  endtask

  task automatic t_prio;
    logic [7:0] d;
    init(8'h00);
    wr(1, 8'hFF);
    pulse(8'h40); pulse(8'h02);
    int_chk("R6 all masked", 1'b0);
    wr(1, 8'hBD);
    int_chk("R6 unmasked request", 1'b1);
    do_ack(d); chk("R6 highest wins", d, 8'h41);
    int_chk("R6 blocked by in-service", 1'b0);
    wr(0, 8'h20);
    int_chk("R9 eoi releases", 1'b1);
    do_ack(d); chk("R6 next line", d, 8'h46);
    wr(1, 8'h00);
    pulse(8'h08);
    int_chk("R6 higher preempts", 1'b1);
    do_ack(d); chk("R6 nested ack", d, 8'h43);
    wr(0, 8'h0B);
    rd(0, d); chk("R9 two in service", d, 8'h48);
    wr(0, 8'h20);
    rd(0, d); chk("R9 nonspecific clears highest", d, 8'h40);
    wr(0, 8'hA0);
    rd(0, d); chk("R9 rotating eoi clears", d, 8'h00);
    pulse(8'h81);
    do_ack(d); chk("R9 base moved past line 6", d, 8'h47);
  endtask

  task automatic t_specific;
    logic [7:0] d;
    init(8'h00);
    pulse(8'h10); do_ack(d); chk("R7 line 4", d, 8'h44);
    pulse(8'h04); do_ack(d); chk("R7 line 2 preempts", d, 8'h42);
    wr(0, 8'h0B);
    rd(0, d); chk("R10 setup", d, 8'h14);
    wr(0, 8'h64);
    rd(0, d); chk("R10 specific eoi", d, 8'h04);
    wr(0, 8'hE2);
    rd(0, d); chk("R10 specific rotating eoi", d, 8'h00);
    pulse(8'h0C); do_ack(d); chk("R10 base after rotate", d, 8'h43);
    wr(0, 8'hC5);
    pulse(8'h60); do_ack(d); chk("R10 set priority", d, 8'h46);
  endtask

  task automatic t_mode_cmds;
    logic [7:0] d;
    init(8'h00);
    pulse(8'h02); do_ack(d); chk("R8 setup", d, 8'h41);
    pulse(8'h20);
    int_chk("R8 blocked", 1'b0);
    wr(1, 8'h02);
    int_chk("R8 masked in-service still blocks", 1'b0);
    wr(0, 8'h68);
    int_chk("R8 special mask on", 1'b1);
    wr(0, 8'h48);
    int_chk("R8 special mask off", 1'b0);
    wr(0, 8'h0B);
    rd(0, d); chk("R8 select in-service", d, 8'h02);
    wr(0, 8'h08);
    rd(0, d); chk("R8 select unchanged without enable", d, 8'h02);
    wr(0, 8'h0A);
    rd(0, d); chk("R8 select request", d, 8'h20);
  endtask

  task automatic t_auto;
    logic [7:0] d;
    init(8'h02);
    pulse(8'h08); do_ack(d); chk("R4 auto ack", d, 8'h43);
    wr(0, 8'h0B);
    rd(0, d); chk("R4 auto eoi no in-service", d, 8'h00);
    wr(0, 8'h80);
    pulse(8'h08); do_ack(d); chk("R11 rotate ack", d, 8'h43);
    pulse(8'h28); do_ack(d); chk("R11 rotated winner", d, 8'h45);
    wr(0, 8'h00);
    pulse(8'h80); do_ack(d); chk("R11 ack line 7", d, 8'h47);
    pulse(8'h41); do_ack(d); chk("R11 rotation off", d, 8'h46);
    init(8'h10);
    pulse(8'h04); do_ack(d); chk("R4 nesting setup", d, 8'h42);
    pulse(8'h04);
    int_chk("R4 special nesting", 1'b1);
  endtask

  task automatic t_poll;
    logic [7:0] d;
    init(8'h00);
    wr(1, 8'h80);
    pulse(8'h50);
    wr(0, 8'h0C);
    rd(0, d); chk("R12 poll line", d, 8'h04);
    rd(0, d); chk("R12 poll disarmed and cleared", d, 8'h40);
    wr(0, 8'h0C);
    rd(1, d); chk("R12 poll next", d, 8'h06);
    wr(0, 8'h0C);
    rd(0, d); chk("R12 poll empty", d, 8'h07);
    rd(1, d); chk("R13 mask read", d, 8'h80);
    pulse(8'h02); do_ack(d); chk("R13 setup", d, 8'h41);
    wr(0, 8'h40);
    wr(0, 8'h0B);
    rd(0, d); chk("R13 command 2 no effect", d, 8'h02);
    rd(1, d); chk("R13 mask kept", d, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_init_paths();
    t_edge_ack();
    t_prio();
    t_specific();
    t_mode_cmds();
    t_auto();
    t_poll();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule